// File: doc/BRIEF.md
# Texture Fetch Clause Engine

This block runs one clause of fetch instructions for a single wavefront. Each instruction names a source register, a destination register and a byte offset. The engine reads the base address from the register file and adds the offset. It sends one read to the level-one cache and later writes the returned word into the destination register. The block only reads global memory. The cache port has no write path.

There are four stages. Fetch reads one instruction word per request from the instruction memory into a single-entry instruction buffer. Decode reads the source register and forms the address. The read stage offers the request to the cache with a tag. The write stage matches each tagged response to its destination and writes the register file.

A clause starts with a start pulse carrying a base address and an instruction count. A done pulse reports that the last result is in the register file. Responses may return in any order. An instruction that depends on an earlier, unfinished load is held in decode until that load has completed.

Top module: `tex_clause_fetch`

## Requirements
- R1: While reset is low and in the first cycle after it, `done`, `imem_req`, `l1_req_valid` and `rf_we` are all 0.
- R2: A start pulse seen while idle latches `start_addr` and `start_count`. The instructions are fetched from `start_addr` upward, one address per instruction, and the address wraps modulo the instruction memory size. `imem_rdata` is taken in the cycle after `imem_req`.
- R3: An instruction word holds the destination register in bits [15:12], the source register in bits [11:8] and an unsigned offset in bits [7:0]. Each instruction sends exactly one cache read, in program order, to the address RF[source] plus the zero-extended offset.
- R4: While `l1_req_valid` is 1 and `l1_req_ready` is 0, the request address and tag stay unchanged in the next cycle.
- R5: Tags are handed out round-robin, 0, 1, … TAGS-1 and then 0 again, with the sequence running on from one clause to the next. A tag is not sent again until its response has arrived, so at most TAGS reads are outstanding.
- R6: Responses may arrive in any order. A response writes `l1_rsp_data` into the destination register of the request with the same tag, and `rf_we` rises in the cycle after the response.
- R7: Decode holds an instruction whose source or destination register matches the destination of any load still in flight. The final register contents therefore equal in-order execution of the clause.
- R8: `done` is a one-cycle pulse in the cycle after the clause's last register write. A clause with a count of 0 gives `done` in the cycle after the start is taken, and it sends no reads and makes no writes.
- R9: A start pulse while a clause is running is ignored. It neither adds instructions nor produces a second `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a clause (taken when idle) |
| start_addr | input | IADDR_W | First instruction address |
| start_count | input | CNT_W | Number of instructions |
| done | output | 1 | Clause complete pulse |
| imem_req | output | 1 | Instruction read request |
| imem_addr | output | IADDR_W | Instruction address |
| imem_rdata | input | 16 | Instruction word, valid one cycle after request |
| rf_raddr | output | RF_AW | Register file read address |
| rf_rdata | input | DATA_W | Register file read data (same cycle) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | RF_AW | Register file write address |
| rf_wdata | output | DATA_W | Register file write data |
| l1_req_valid | output | 1 | Cache read request valid |
| l1_req_ready | input | 1 | Cache accepts request |
| l1_req_addr | output | DATA_W | Read address |
| l1_req_tag | output | TAG_W | Request tag |
| l1_rsp_valid | input | 1 | Response valid |
| l1_rsp_tag | input | TAG_W | Response tag |
| l1_rsp_data | input | DATA_W | Response data |

## Verification
The hardest case to reach from the ports is a read-after-write or write-after-write dependence between loads, with the cache returning their data in reverse order. The interlock only matters when the producing load is still in flight at the moment the consumer reaches decode. To force this, the cache model holds responses back until all tags are in use or the request stream goes quiet, and then releases them newest first. Chained clauses use a destination as the next source, and the final register file is compared with a sequential model.

// File: rtl/tex_clause_fetch.sv
module tex_clause_fetch #(
  parameter int IADDR_W = 8,
  parameter int CNT_W   = 8,
  parameter int RF_AW   = 4,
  parameter int DATA_W  = 32,
  parameter int OFF_W   = 8,
  parameter int TAGS    = 4,
  localparam int TAG_W   = (TAGS > 1) ? $clog2(TAGS) : 1,
  localparam int INSTR_W = 2 * RF_AW + OFF_W,
  localparam int NSLOT   = 1 << TAG_W,
  localparam int OC_W    = $clog2(TAGS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [IADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]   start_count,
  output logic               done,
  output logic               imem_req,
  output logic [IADDR_W-1:0] imem_addr,
  input  logic [INSTR_W-1:0] imem_rdata,
  output logic [RF_AW-1:0]   rf_raddr,
  input  logic [DATA_W-1:0]  rf_rdata,
  output logic               rf_we,
  output logic [RF_AW-1:0]   rf_waddr,
  output logic [DATA_W-1:0]  rf_wdata,
  output logic               l1_req_valid,
  input  logic               l1_req_ready,
  output logic [DATA_W-1:0]  l1_req_addr,
  output logic [TAG_W-1:0]   l1_req_tag,
  input  logic               l1_rsp_valid,
  input  logic [TAG_W-1:0]   l1_rsp_tag,
  input  logic [DATA_W-1:0]  l1_rsp_data
);

  logic               active;
  logic [IADDR_W-1:0] pc;
  logic [CNT_W-1:0]   total, fetch_cnt, issue_cnt;
  logic               fetch_pend;
  logic               ibuf_valid;
  logic [INSTR_W-1:0] ibuf;
  logic               rd_valid;
  logic [DATA_W-1:0]  rd_addr;
  logic [RF_AW-1:0]   rd_dst;
  logic [NSLOT-1:0]   slot_v;
  logic [RF_AW-1:0]   slot_dst [NSLOT];
  logic [TAG_W-1:0]   alloc_ptr;
  logic [OC_W-1:0]    out_cnt;
  logic               wb_valid;
  logic [RF_AW-1:0]   wb_reg;
  logic [DATA_W-1:0]  wb_data;

  logic [RF_AW-1:0] dec_dst, dec_src;
  logic [OFF_W-1:0] dec_off;
  logic hazard, ibuf_take, rd_fire, rsp_hit, fetch_go;

  assign dec_dst = ibuf[INSTR_W-1 -: RF_AW];
  assign dec_src = ibuf[OFF_W +: RF_AW];
  assign dec_off = ibuf[OFF_W-1:0];

  always_comb begin
    hazard = 1'b0;
    for (int i = 0; i < TAGS; i++)
      if (slot_v[i] && (slot_dst[i] == dec_src || slot_dst[i] == dec_dst)) hazard = 1'b1;
    if (rd_valid && (rd_dst == dec_src || rd_dst == dec_dst)) hazard = 1'b1;
    if (wb_valid && (wb_reg == dec_src || wb_reg == dec_dst)) hazard = 1'b1;
  end

  assign l1_req_valid = rd_valid && !slot_v[alloc_ptr];
  assign l1_req_addr  = rd_addr;
  assign l1_req_tag   = alloc_ptr;
  assign rd_fire      = l1_req_valid && l1_req_ready;
  assign rsp_hit      = l1_rsp_valid && slot_v[l1_rsp_tag];
  assign ibuf_take    = ibuf_valid && !hazard && (!rd_valid || rd_fire);
  assign fetch_go     = active && (fetch_cnt != total) && !fetch_pend && (!ibuf_valid || ibuf_take);
  assign done         = active && (issue_cnt == total) && (out_cnt == '0) && !wb_valid;

  assign imem_req = fetch_go;
  assign imem_addr = pc;
  assign rf_raddr = dec_src;
  assign rf_we    = wb_valid;
  assign rf_waddr = wb_reg;
  assign rf_wdata = wb_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      pc <= '0;
      total <= '0;
      fetch_cnt <= '0;
      issue_cnt <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        pc <= start_addr;
        total <= start_count;
        fetch_cnt <= '0;
        issue_cnt <= '0;
      end
    end else begin
      if (done) active <= 1'b0;
      if (fetch_go) begin
        pc <= pc + 1'b1;
        fetch_cnt <= fetch_cnt + 1'b1;
      end
      if (rd_fire) issue_cnt <= issue_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_pend <= 1'b0;
      ibuf_valid <= 1'b0;
      ibuf <= '0;
    end else if (fetch_pend) begin
      fetch_pend <= 1'b0;
      ibuf_valid <= 1'b1;
      ibuf <= imem_rdata;
    end else begin
      fetch_pend <= fetch_go;
      if (ibuf_take) ibuf_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_addr <= '0;
      rd_dst <= '0;
    end else if (ibuf_take) begin
      rd_valid <= 1'b1;
      rd_addr <= rf_rdata + DATA_W'(dec_off);
      rd_dst <= dec_dst;
    end else if (rd_fire) begin
      rd_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_v <= '0;
      alloc_ptr <= '0;
      out_cnt <= '0;
    end else begin
      if (rd_fire) begin
        slot_v[alloc_ptr] <= 1'b1;
        alloc_ptr <= (alloc_ptr == TAG_W'(TAGS - 1)) ? '0 : alloc_ptr + 1'b1;
      end
      if (rsp_hit) slot_v[l1_rsp_tag] <= 1'b0;
      out_cnt <= out_cnt + OC_W'(rd_fire) - OC_W'(rsp_hit);
    end
  end

  always_ff @(posedge clk)
    if (rd_fire) slot_dst[alloc_ptr] <= rd_dst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_reg <= '0;
      wb_data <= '0;
    end else begin
      wb_valid <= rsp_hit;
      wb_reg <= slot_dst[l1_rsp_tag];
      wb_data <= l1_rsp_data;
    end
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_req_valid && !l1_req_ready) |=> (l1_req_valid && $stable(l1_req_addr) && $stable(l1_req_tag)));

  // R5
  out_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(out_cnt) == $countones(slot_v)) && (out_cnt <= OC_W'(TAGS)));

  // R6
  wb_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(l1_rsp_valid));

  // R8
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(rf_we) || $past(start)));

endmodule

// File: tb/tex_clause_fetch_tb.sv
`timescale 1ns/1ps
module tex_clause_fetch_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic start = 1'b0;
  logic [7:0] start_addr = '0;
  logic [7:0] start_count = '0;
  logic done, imem_req, rf_we, l1_req_valid;
  logic [7:0] imem_addr;
  logic [15:0] imem_rdata;
  logic [3:0] rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata, l1_req_addr;
  logic [1:0] l1_req_tag;
  logic l1_req_ready = 1'b1;
  logic l1_rsp_valid = 1'b0;
  logic [1:0] l1_rsp_tag = '0;
  logic [31:0] l1_rsp_data = '0;

  tex_clause_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .start_count(start_count),
    .done(done), .imem_req(imem_req), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .l1_req_valid(l1_req_valid), .l1_req_ready(l1_req_ready), .l1_req_addr(l1_req_addr),
    .l1_req_tag(l1_req_tag), .l1_rsp_valid(l1_rsp_valid), .l1_rsp_tag(l1_rsp_tag), .l1_rsp_data(l1_rsp_data));

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction

  function automatic logic [31:0] initv(input int i);
    return 32'h1000 + 32'(i) * 32'h100;
  endfunction

  // memories around the block
  logic [15:0] imem [256];
  logic [31:0] rf [16];
  logic init_req = 1'b0;
  always @(posedge clk) begin
    if (imem_req) imem_rdata <= imem[imem_addr];
    if (init_req) begin
      for (int i = 0; i < 16; i++) rf[i] <= initv(i);
    end else if (rf_we) rf[rf_waddr] <= rf_wdata;
  end
  assign rf_rdata = rf[rf_raddr];

  // cache model and monitor
  int cyc = 0, rdy_mode = 0, rsp_mode = 0;
  int qn = 0, idle = 0, peak = 0;
  logic [1:0] q_tag [8];
  logic [31:0] q_dat [8];
  int q_age [8];
  int wr_cnt = 0, done_cnt = 0, req_cnt = 0, last_we = 0, done_cyc = 0;
  int tag_err = 0, hold_err = 0;
  logic [1:0] exp_tag = '0;
  bit stalled = 0;
  logic [31:0] st_addr;
  logic [1:0] st_tag;

  always @(negedge clk) begin
    int idx;
    cyc++;
    if (rf_we) begin wr_cnt++; last_we = cyc; end
    if (done) begin done_cnt++; done_cyc = cyc; end
    if (stalled && !(l1_req_valid && l1_req_addr == st_addr && l1_req_tag == st_tag)) hold_err++;
    l1_rsp_valid = 1'b0;
    for (int i = 0; i < qn; i++) q_age[i]++;
    idx = -1;
    if (rsp_mode == 0) begin
      if (qn > 0 && q_age[0] >= 1) idx = 0;
    end else if ((qn >= 4 || (qn > 0 && idle >= 4)) && q_age[qn-1] >= 1) idx = qn - 1;
    if (idx >= 0) begin
      l1_rsp_valid = 1'b1;
      l1_rsp_tag = q_tag[idx];
      l1_rsp_data = q_dat[idx];
      for (int i = idx; i < qn - 1; i++) begin
        q_tag[i] = q_tag[i+1]; q_dat[i] = q_dat[i+1]; q_age[i] = q_age[i+1];
      end
      qn--;
    end
    l1_req_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    stalled = l1_req_valid && !l1_req_ready;
    st_addr = l1_req_addr;
    st_tag = l1_req_tag;
    if (l1_req_valid && l1_req_ready) begin
      for (int i = 0; i < qn; i++) if (q_tag[i] == l1_req_tag) tag_err++;
      if (l1_req_tag != exp_tag) tag_err++;
      exp_tag = exp_tag + 2'd1;
      q_tag[qn] = l1_req_tag; q_dat[qn] = memf(l1_req_addr); q_age[qn] = 0;
      qn++; req_cnt++; idle = 0;
    end else idle++;
    if (qn > peak) peak = qn;
  end

  logic [15:0] prog [16];
  logic [31:0] mdl [16];

  task automatic init_rf();
    @(negedge clk); init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
    for (int i = 0; i < 16; i++) mdl[i] = initv(i);
  endtask

  task automatic pulse_start(input logic [7:0] base, input logic [7:0] n);
    @(negedge clk);
    start = 1'b1; start_addr = base; start_count = n;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int prev, input string req);
    int t = 0;
    while (done_cnt == prev && t < 3000) begin @(negedge clk); #1; t++; end
    chk(done_cnt == prev + 1, req, done_cnt, prev + 1);
  endtask

  task automatic run_clause(input logic [7:0] base, input int n, input string req);
    int d0, bad;
    init_rf();
    for (int i = 0; i < n; i++) begin
      imem[8'(base + 8'(i))] = prog[i];
      mdl[prog[i][15:12]] = memf(mdl[prog[i][11:8]] + {24'h0, prog[i][7:0]});
    end
    d0 = done_cnt;
    pulse_start(base, 8'(n));
    wait_done(d0, {req, " R8 done seen"});
    repeat (3) @(negedge clk);
    #1;
    bad = -1;
    for (int i = 0; i < 16; i++) if (bad < 0 && rf[i] !== mdl[i]) bad = i;
    if (bad < 0) chk(1'b1, {req, " rf contents"}, 0, 0);
    else chk(1'b0, {req, " rf contents"}, rf[bad], mdl[bad]);
    // R8 done exactly one cycle after last write
    chk(done_cyc == last_we + 1, "R8 done timing", done_cyc, last_we + 1);
  endtask

  localparam logic [15:0] TBL [8] = '{16'h2104, 16'h7A80, 16'h0FFF, 16'hF000,
                                      16'h3311, 16'h9C7F, 16'h4545, 16'hE2C0};

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int w0, r0, d0;
    for (int i = 0; i < 256; i++) imem[i] = 16'h0000;
    repeat (4) @(negedge clk);
    #1;
    // R1 outputs idle during reset
    chk(!done && !imem_req && !l1_req_valid && !rf_we, "R1 in reset",
        {28'h0, done, imem_req, l1_req_valid, rf_we}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!done && !imem_req && !l1_req_valid && !rf_we, "R1 after reset",
        {28'h0, done, imem_req, l1_req_valid, rf_we}, 0);

    // table: single-instruction clauses at varied bases (R2, R3, R6)
    for (int k = 0; k < 8; k++) begin
      r0 = req_cnt;
      prog[0] = TBL[k];
      run_clause(8'(k * 16 + 3), 1, "R3 table vector");
      chk(req_cnt == r0 + 1, "R3 one request per instruction", req_cnt - r0, 1);
    end

    // R4 stalled ready, in-order responses, base wraps (R2)
    rdy_mode = 1;
    prog[0] = 16'h1208; prog[1] = 16'h2310; prog[2] = 16'h3420; prog[3] = 16'h4540; prog[4] = 16'h5680;
    r0 = req_cnt;
    run_clause(8'hFE, 5, "R2 wrapped base");
    chk(req_cnt == r0 + 5, "R3 request count", req_cnt - r0, 5);
    chk(hold_err == 0, "R4 request held while stalled", hold_err, 0);
    rdy_mode = 0;

    // R6 reverse-order responses, independent loads, tag limit (R5)
    rsp_mode = 1; peak = 0;
    prog[0] = 16'h8001; prog[1] = 16'h9102; prog[2] = 16'hA203;
    prog[3] = 16'hB304; prog[4] = 16'hC405; prog[5] = 16'hD506;
    run_clause(8'h60, 6, "R6 out-of-order");
    chk(peak == 4, "R5 peak outstanding", peak, 4);

    // R7 dependent chain with reordering
    prog[0] = 16'h3104; prog[1] = 16'h5308; prog[2] = 16'h3510; prog[3] = 16'h6702; prog[4] = 16'h7620;
    run_clause(8'h20, 5, "R7 interlock");
    rsp_mode = 0;
    chk(tag_err == 0, "R5 tag order and uniqueness", tag_err, 0);

    // R8 zero-length clause
    w0 = wr_cnt; r0 = req_cnt; d0 = done_cnt;
    pulse_start(8'h10, 8'd0);
    #1;
    chk(done_cnt == d0 + 1, "R8 zero count done", done_cnt, d0 + 1);
    repeat (3) @(negedge clk);
    #1;
    chk(wr_cnt == w0 && req_cnt == r0, "R8 zero count no traffic", wr_cnt - w0, 0);

    // R9 start ignored while busy
    init_rf();
    prog[0] = 16'h1104; prog[1] = 16'h2208; prog[2] = 16'h4312;
    for (int i = 0; i < 3; i++) begin
      imem[8'h40 + 8'(i)] = prog[i];
      mdl[prog[i][15:12]] = memf(mdl[prog[i][11:8]] + {24'h0, prog[i][7:0]});
    end
    for (int i = 0; i < 8; i++) imem[8'h80 + 8'(i)] = 16'hF1AA;
    w0 = wr_cnt; d0 = done_cnt;
    pulse_start(8'h40, 8'd3);
    pulse_start(8'h80, 8'd7);
    wait_done(d0, "R9 done after busy start");
    repeat (40) @(negedge clk);
    #1;
    chk(wr_cnt == w0 + 3, "R9 write count", wr_cnt - w0, 3);
    chk(done_cnt == d0 + 1, "R9 single done", done_cnt - d0, 1);
    chk(rf[15] === initv(15) && rf[4] === mdl[4], "R9 registers", rf[15], initv(15));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule